// File: doc/BRIEF.md
# Frequency Lock Detector with Hysteresis

This block tells a clock recovery loop whether its divided-down recovered clock runs at the same frequency as a local reference clock. Both clocks nominally run at 38.88 MHz, with the measured clock being the recovered high-speed clock divided by 64. The reference domain counts out a fixed window of `2^WIN_LOG2` reference cycles. The measured-clock domain counts its own cycles over the same window. At the end of each window, the block forms the absolute difference between the measured count and the nominal count `2^WIN_LOG2`.

Lock is reported with hysteresis. A locked loop keeps lock until the difference exceeds a wide unlock threshold. An unlocked loop gets lock back only when the difference drops below a narrower relock threshold. A select input picks one of two relock thresholds. With the default window of 2^18 reference cycles, the counts 128, 32 and 8 stand for 488, 122 and 30 ppm.

The block also drives a steering output. This output tells the loop to follow the reference-frequency detector while acquiring, or the data phase detector once locked. An active-low override forces reference steering at any time.

Top module: `freq_lock_detect`

## Requirements
- R1: While reset is asserted and after it is released, `lock` is 0 and `use_phase_det` is 0 (frequency detector), until a window evaluation changes the lock state.
- R2: A window lasts `2^WIN_LOG2` reference cycles. The window-end event reaches the measured domain through a toggle synchronizer. The difference |measured cycles in the window − 2^WIN_LOG2| is evaluated once per window, and `lock` changes only on an evaluation cycle.
- R3: While `lock` is 1, it stays 1 as long as each evaluated difference is at most `UNLOCK_CNT`. This holds whether the measured clock is slower or faster than the reference.
- R4: While `lock` is 1, an evaluated difference greater than `UNLOCK_CNT` clears `lock`. This holds for both signs of frequency error.
- R5: While `lock` is 0, `lock` is set only by an evaluated difference strictly below the selected relock threshold. A difference between the relock threshold and `UNLOCK_CNT` leaves it at 0.
- R6: `relock_sel` = 1 selects the wide relock threshold `RELOCK_WIDE_CNT`. `relock_sel` = 0 selects the narrow threshold `RELOCK_NARROW_CNT`.
- R7: The first window end after reset only primes the detector. It is never evaluated, so `lock` cannot rise before the end of the second window.
- R8: `use_phase_det` is 1 only when `lock` is 1 and `force_ref_n` is 1. Driving `force_ref_n` low forces `use_phase_det` to 0 and does not change `lock`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| meas_clk | input | 1 | Divided recovered clock under measurement |
| ref_clk | input | 1 | Reference clock, same nominal frequency |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously in each domain |
| relock_sel | input | 1 | 1: wide relock threshold, 0: narrow relock threshold |
| force_ref_n | input | 1 | Active low: force steering to the reference-frequency detector |
| lock | output | 1 | Frequency lock, active high (meas_clk domain) |
| use_phase_det | output | 1 | 1: steer by data phase detector, 0: by reference-frequency detector |

## Verification
The hardest situation to reach from the ports is an unlocked loop whose error sits inside the hysteresis band. The error must be larger than the relock threshold yet no larger than the unlock threshold, so lock must stay low even though a locked loop would keep lock at that error. The stimulus first pushes the measured clock far off frequency to force unlock. It then moves to an offset inside the band and holds it for several windows, and only afterwards switches `relock_sel` to the wide threshold to show that lock returns. Frequency offsets are programmed in ppm on the measured clock period and are chosen well clear of each threshold, so the ±1 count quantization of a window never decides the outcome. Offsets are applied with both signs.

// File: rtl/fld_pkg.sv
package fld_pkg;
  typedef enum logic {
    STEER_FREQ  = 1'b0,
    STEER_PHASE = 1'b1
  } steer_e;
endpackage

// File: rtl/fld_rst_sync.sv
module fld_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_n_sync = stage_q[1];
endmodule

// File: rtl/fld_ref_window.sv
module fld_ref_window #(
  parameter int WIN_LOG2 = 18
) (
  input  logic clk,
  input  logic rst_n,
  output logic win_tgl
);
  logic [WIN_LOG2-1:0] cnt_q, cnt_d;
  logic                tgl_q, tgl_d;
  logic                wrap;

  assign wrap = (cnt_q == {WIN_LOG2{1'b1}});

  always_comb begin
    cnt_d = cnt_q + 1'b1;
    tgl_d = wrap ? ~tgl_q : tgl_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      tgl_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      tgl_q <= tgl_d;
    end
  end

  assign win_tgl = tgl_q;

  AST_REF_TOGGLE_AT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (tgl_q != $past(tgl_q)) |-> ($past(cnt_q) == {WIN_LOG2{1'b1}})); // R2
endmodule

// File: rtl/fld_meas_eval.sv
module fld_meas_eval #(
  parameter int WIN_LOG2          = 18,
  parameter int UNLOCK_CNT        = 128,
  parameter int RELOCK_WIDE_CNT   = 32,
  parameter int RELOCK_NARROW_CNT = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic win_tgl_async,
  input  logic relock_sel,
  output logic lock
);
  localparam int CW = WIN_LOG2 + 2;
  localparam logic [CW-1:0] NOMINAL  = CW'(1) << WIN_LOG2;
  localparam logic [CW-1:0] CNT_MAX  = {CW{1'b1}};
  localparam logic [CW-1:0] UNLOCK_L = CW'(UNLOCK_CNT);
  localparam logic [CW-1:0] WIDE_L   = CW'(RELOCK_WIDE_CNT);
  localparam logic [CW-1:0] NARROW_L = CW'(RELOCK_NARROW_CNT);

  logic [2:0]    sync_q;
  logic          win_end;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [CW-1:0] win_cnt;
  logic [CW-1:0] diff;
  logic [CW-1:0] relock_thr;
  logic          primed_q, primed_d;
  logic          lock_q, lock_d;
  logic          eval_en;

  // toggle synchronizer for the window-end event
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 3'b000;
    else        sync_q <= {sync_q[1:0], win_tgl_async};
  end
  assign win_end = sync_q[2] ^ sync_q[1];

  assign win_cnt    = (cnt_q == CNT_MAX) ? cnt_q : cnt_q + 1'b1;
  assign diff       = (win_cnt >= NOMINAL) ? (win_cnt - NOMINAL) : (NOMINAL - win_cnt);
  assign relock_thr = relock_sel ? WIDE_L : NARROW_L;
  assign eval_en    = win_end && primed_q;

  always_comb begin
    cnt_d    = win_end ? '0 : win_cnt;
    primed_d = primed_q | win_end;
    lock_d   = lock_q;
    if (eval_en) begin
      if (lock_q && (diff > UNLOCK_L))        lock_d = 1'b0;
      else if (!lock_q && (diff < relock_thr)) lock_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      primed_q <= 1'b0;
      lock_q   <= 1'b0;
    end else begin
      cnt_q    <= cnt_d;
      primed_q <= primed_d;
      lock_q   <= lock_d;
    end
  end

  assign lock = lock_q;

  AST_LOCK_AT_WINDOW_END: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_q != $past(lock_q)) |-> $past(eval_en)); // R2
  AST_DROP_ABOVE_UNLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lock_q) |-> ($past(diff) > UNLOCK_L)); // R4
  AST_RISE_BELOW_RELOCK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lock_q) |-> ($past(diff) < $past(relock_thr))); // R5
  AST_NO_EARLY_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lock_q) |-> $past(primed_q)); // R7
endmodule

// File: rtl/freq_lock_detect.sv
module freq_lock_detect #(
  parameter int WIN_LOG2          = 18,
  parameter int UNLOCK_CNT        = 128,
  parameter int RELOCK_WIDE_CNT   = 32,
  parameter int RELOCK_NARROW_CNT = 8
) (
  input  logic meas_clk,
  input  logic ref_clk,
  input  logic rst_n,
  input  logic relock_sel,
  input  logic force_ref_n,
  output logic lock,
  output logic use_phase_det
);
  import fld_pkg::*;

  logic   rst_ref_n, rst_meas_n;
  logic   win_tgl;
  logic   lock_int;
  steer_e steer;

  fld_rst_sync i_rst_ref  (.clk(ref_clk),  .rst_n(rst_n), .rst_n_sync(rst_ref_n));
  fld_rst_sync i_rst_meas (.clk(meas_clk), .rst_n(rst_n), .rst_n_sync(rst_meas_n));

  fld_ref_window #(.WIN_LOG2(WIN_LOG2)) i_ref_window (
    .clk     (ref_clk),
    .rst_n   (rst_ref_n),
    .win_tgl (win_tgl)
  );

  fld_meas_eval #(
    .WIN_LOG2          (WIN_LOG2),
    .UNLOCK_CNT        (UNLOCK_CNT),
    .RELOCK_WIDE_CNT   (RELOCK_WIDE_CNT),
    .RELOCK_NARROW_CNT (RELOCK_NARROW_CNT)
  ) i_meas_eval (
    .clk           (meas_clk),
    .rst_n         (rst_meas_n),
    .win_tgl_async (win_tgl),
    .relock_sel    (relock_sel),
    .lock          (lock_int)
  );

  assign steer         = (lock_int && force_ref_n) ? STEER_PHASE : STEER_FREQ;
  assign lock          = lock_int;
  assign use_phase_det = steer;

  AST_OVERRIDE_KEEPS_LOCK: assert property (@(posedge meas_clk) disable iff (!rst_meas_n)
    ($fell(force_ref_n) && $past(lock_int)) |-> lock_int); // R8
endmodule

// File: tb/test_freq_lock_detect.sv
`timescale 1ns/1ps
module test_freq_lock_detect;
  localparam int WL  = 10;
  localparam int WIN = 1 << WL;

  logic meas_clk = 1'b0;
  logic ref_clk  = 1'b0;
  logic rst_n, relock_sel, force_ref_n;
  logic lock, use_phase_det;
  real  meas_half = 5.0;
  int   checks = 0;
  int   errors = 0;
  bit   done   = 0;

  freq_lock_detect #(
    .WIN_LOG2(WL), .UNLOCK_CNT(16), .RELOCK_WIDE_CNT(8), .RELOCK_NARROW_CNT(2)
  ) i_freq_lock_detect (
    .meas_clk(meas_clk), .ref_clk(ref_clk), .rst_n(rst_n),
    .relock_sel(relock_sel), .force_ref_n(force_ref_n),
    .lock(lock), .use_phase_det(use_phase_det)
  );

  always #5 ref_clk = ~ref_clk;
  always #(meas_half) meas_clk = ~meas_clk;

  task automatic chk(string req, string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic set_ppm(int ppm);
    meas_half = 5.0 * (1.0 + ppm * 1.0e-6);
  endtask

  task automatic wait_ref(int n);
    repeat (n) @(negedge ref_clk);
  endtask

  task automatic wait_windows(int n);
    wait_ref(n * WIN + 60);
  endtask

  task automatic t_reset_and_first_window();
    rst_n = 1'b0; relock_sel = 1'b0; force_ref_n = 1'b1; set_ppm(0);
    wait_ref(10);
    chk("R1", "lock in reset", lock, 1'b0);
    chk("R1", "steer in reset", use_phase_det, 1'b0);
    rst_n = 1'b1;
    wait_ref(WIN + WIN / 2);
    chk("R7", "no lock after first window", lock, 1'b0);
    chk("R1", "steer before lock", use_phase_det, 1'b0);
    wait_ref(WIN);
    chk("R7", "lock after second window", lock, 1'b1);
    chk("R8", "phase steering when locked", use_phase_det, 1'b1);
  endtask

  task automatic t_override();
    force_ref_n = 1'b0;
    wait_ref(3);
    chk("R8", "override forces freq steering", use_phase_det, 1'b0);
    chk("R8", "override leaves lock", lock, 1'b1);
    force_ref_n = 1'b1;
    wait_ref(3);
    chk("R8", "release restores phase steering", use_phase_det, 1'b1);
  endtask

  task automatic t_hold_in_band();
    set_ppm(12000);
    wait_windows(4);
    chk("R3", "hold lock slow 12000ppm", lock, 1'b1);
    set_ppm(-12000);
    wait_windows(4);
    chk("R3", "hold lock fast 12000ppm", lock, 1'b1);
  endtask

  task automatic t_drop_slow();
    set_ppm(30000);
    wait_windows(3);
    chk("R4", "drop lock slow 30000ppm", lock, 1'b0);
    chk("R8", "freq steering after drop", use_phase_det, 1'b0);
  endtask

  task automatic t_relock_band();
    relock_sel = 1'b1; set_ppm(12000);
    wait_windows(4);
    chk("R5", "no relock at 12000ppm wide", lock, 1'b0);
    relock_sel = 1'b0; set_ppm(5000);
    wait_windows(4);
    chk("R6", "no relock at 5000ppm narrow", lock, 1'b0);
    relock_sel = 1'b1;
    wait_windows(3);
    chk("R6", "relock at 5000ppm wide", lock, 1'b1);
  endtask

  task automatic t_drop_fast_relock_narrow();
    set_ppm(-30000);
    wait_windows(3);
    chk("R4", "drop lock fast 30000ppm", lock, 1'b0);
    relock_sel = 1'b0; set_ppm(0);
    wait_windows(3);
    chk("R6", "relock at 0ppm narrow", lock, 1'b1);
  endtask

  task automatic t_override_while_unlocked();
    set_ppm(30000);
    wait_windows(3);
    chk("R4", "drop before override test", lock, 1'b0);
    force_ref_n = 1'b0; set_ppm(0);
    wait_windows(3);
    chk("R8", "lock regained under override", lock, 1'b1);
    chk("R8", "override keeps freq steering", use_phase_det, 1'b0);
    force_ref_n = 1'b1;
    wait_ref(3);
    chk("R8", "phase steering after release", use_phase_det, 1'b1);
  endtask

  initial begin
    t_reset_and_first_window();
    t_override();
    t_hold_in_band();
    t_drop_slow();
    t_relock_band();
    t_drop_fast_relock_narrow();
    t_override_while_unlocked();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #1500000;
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule